// File: doc/BRIEF.md
# Receive Elasticity Buffer with Start Threshold

This block sits in a reduced-pin receive path, between the clock recovered from the line and the local reference clock. Symbols of SYM_W bits (dibits by default) arrive on the recovered clock while a data-valid line is high. They leave on the local clock. A small dual-clock store of 32 bits absorbs the frequency offset between the two clocks for the length of one frame. The write and read pointers cross between the domains as gray codes.

A frame is not released at once. The read side waits until the store holds a programmable number of bits, set by a 2-bit select, and then sends one symbol per clock until the frame's end marker comes out. A larger threshold tolerates more drift on long frames. A smaller one gives less latency. If the writer finds the store full, or the reader finds it empty in the middle of a frame, the rest of that frame is corrupted on purpose: its symbols are inverted and the error line is raised, so the downstream frame check fails. Two sticky flags record which of the two conditions happened. Both flags clear on a read strobe.

Top module: `rx_elastic_buf`

## Requirements
- R1: Once both resets are released, rd_dv, rd_err, stat_ovr and stat_und are all 0.
- R2: If the writer runs slightly faster than the reader and the frame is at least as long as the threshold, the frame's symbols come out in order with no gap on rd_dv. rd_err stays 0 and rd_dv falls after the last symbol.
- R3: thr_sel sets the start threshold in bits: 1 = 4, 2 = 8, 3 = 12, 0 = 16. The first symbol of each frame leaves only after at least threshold/SYM_W symbols of that frame have been written. Each new frame waits for the threshold again.
- R4: A symbol that arrives while the store holds 32 bits is dropped. From then on the frame carries rd_err, and stat_ovr is set when the damaged part of the frame is read out. If the damage is first seen at the frame's end marker, one extra all-ones symbol with rd_err is sent before rd_dv falls.
- R5: If the reader finds the store empty while a frame is in progress, it emits an all-ones symbol with rd_dv and rd_err both high. It also sets stat_und and waits for the next symbol.
- R6: After the first error in a frame, every later data symbol of that frame comes out bit-inverted. rd_err stays high until rd_dv falls.
- R7: stat_ovr and stat_und each stay set until stat_rd is pulsed. They read 0 on the clock after the pulse, unless a new error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered receive clock (write side) |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wr_dv | input | 1 | Receive data valid, frame envelope |
| wr_data | input | SYM_W | Received symbol |
| rclk | input | 1 | Local reference clock (read side) |
| rrst | input | 1 | Synchronous active-high reset, read side |
| thr_sel | input | 2 | Start threshold select (1=4, 2=8, 3=12, 0=16 bits) |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| rd_dv | output | 1 | Output data valid |
| rd_data | output | SYM_W | Output symbol |
| rd_err | output | 1 | Frame corrupted by overrun or underrun |
| stat_ovr | output | 1 | Sticky overrun flag |
| stat_und | output | 1 | Sticky underrun flag |

## Verification
The hardest states to reach are overrun and underrun. Both need a sustained clock offset that drains or fills the 32-bit store partway through a frame. The bench varies the period of the recovered clock between frames: about 25 % fast for overrun and 50 % slow for underrun. In those frames it sends a constant symbol, so the inverted symbols, the all-ones fill symbols and the untouched prefix can each be told apart at the output. The clean frames run with a writer 0.5 % fast, which keeps the fill well below full at every threshold used.

// File: rtl/rxeb_pkg.sv
`timescale 1ns/1ps
package rxeb_pkg;
  typedef enum logic [1:0] {RD_IDLE, RD_RUN, RD_TAIL} rd_state_t;

  // Start threshold in bits for the 2-bit select
  function automatic int unsigned thr_bits(input logic [1:0] sel);
    return (sel == 2'd0) ? 16 : 4 * int'(sel);
  endfunction
endpackage

// File: rtl/rxeb_sync.sv
`timescale 1ns/1ps
module rxeb_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rxeb_mem.sv
`timescale 1ns/1ps
module rxeb_mem #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxeb_wr_side.sv
`timescale 1ns/1ps
module rxeb_wr_side #(
  parameter int SYM_W = 2,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv,
  input  logic [SYM_W-1:0] data,
  input  logic [AW:0]      rgray_s,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [SYM_W+1:0] wentry,
  output logic [AW:0]      wgray
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0] wbin, rbin_s, fill, wbin_nx;
  logic full, dv_q, ovr_pend, eof_pend, need_eof, mk_wr, dat_wr, drop;

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign fill     = wbin - rbin_s;
  assign full     = (fill == (AW+1)'(DEPTH));
  assign need_eof = eof_pend | (dv_q & ~dv);
  assign mk_wr    = need_eof & ~full;
  assign dat_wr   = dv & ~need_eof & ~full;
  assign drop     = dv & (full | need_eof);
  assign we       = mk_wr | dat_wr;
  assign waddr    = wbin[AW-1:0];
  assign wentry   = mk_wr ? {ovr_pend, 1'b1, {SYM_W{1'b0}}} : {ovr_pend, 1'b0, data};
  assign wbin_nx  = wbin + (AW+1)'(we);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin     <= '0;
      wgray    <= '0;
      dv_q     <= 1'b0;
      ovr_pend <= 1'b0;
      eof_pend <= 1'b0;
    end else begin
      dv_q     <= dv;
      wbin     <= wbin_nx;
      wgray    <= wbin_nx ^ (wbin_nx >> 1);
      eof_pend <= need_eof & ~mk_wr;
      if (drop)       ovr_pend <= 1'b1;
      else if (mk_wr) ovr_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rxeb_rd_side.sv
`timescale 1ns/1ps
module rxeb_rd_side
  import rxeb_pkg::*;
#(
  parameter int SYM_W = 2,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       thr_sel,
  input  logic             stat_rd,
  input  logic [AW:0]      wgray_s,
  input  logic [SYM_W+1:0] rentry,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic             rd_dv,
  output logic [SYM_W-1:0] rd_data,
  output logic             rd_err,
  output logic             stat_ovr,
  output logic             stat_und
);
  rd_state_t st;
  logic [AW:0] wbin_s, rbin, count, thr_ent, rbin_nx;
  logic avail, pop, frm_err, e_err, e_eof, set_ovr, set_und, err_now;
  logic [SYM_W-1:0] e_data;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign count   = wbin_s - rbin;
  assign thr_ent = (AW+1)'(thr_bits(thr_sel) / SYM_W);
  assign avail   = (count != '0);
  assign pop     = avail & (((st == RD_IDLE) & (count >= thr_ent)) | (st == RD_RUN));
  assign {e_err, e_eof, e_data} = rentry;
  assign err_now = frm_err | e_err;
  assign set_ovr = pop & e_err;
  assign set_und = (st == RD_RUN) & ~avail;
  assign raddr   = rbin[AW-1:0];
  assign rbin_nx = rbin + (AW+1)'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RD_IDLE;
      rbin     <= '0;
      rgray    <= '0;
      rd_dv    <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
      frm_err  <= 1'b0;
      stat_ovr <= 1'b0;
      stat_und <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rbin_nx ^ (rbin_nx >> 1);
      stat_ovr <= (stat_ovr & ~stat_rd) | set_ovr;
      stat_und <= (stat_und & ~stat_rd) | set_und;
      if (pop && e_eof) begin
        frm_err <= 1'b0;
        rd_data <= '1;
        rd_dv   <= e_err;
        rd_err  <= e_err;
        st      <= e_err ? RD_TAIL : RD_IDLE;
      end else if (pop) begin
        rd_dv   <= 1'b1;
        rd_err  <= err_now;
        rd_data <= err_now ? ~e_data : e_data;
        frm_err <= err_now;
        st      <= RD_RUN;
      end else if (set_und) begin
        rd_dv   <= 1'b1;
        rd_err  <= 1'b1;
        rd_data <= '1;
        frm_err <= 1'b1;
      end else begin
        rd_dv   <= 1'b0;
        rd_err  <= 1'b0;
        frm_err <= 1'b0;
        st      <= RD_IDLE;
      end
    end
  end
endmodule

// File: rtl/rx_elastic_buf.sv
`timescale 1ns/1ps
module rx_elastic_buf #(
  parameter int SYM_W    = 2,
  parameter int BUF_BITS = 32,
  parameter int SYNC_STG = 2
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wr_dv,
  input  logic [SYM_W-1:0] wr_data,
  input  logic             rclk,
  input  logic             rrst,
  input  logic [1:0]       thr_sel,
  input  logic             stat_rd,
  output logic             rd_dv,
  output logic [SYM_W-1:0] rd_data,
  output logic             rd_err,
  output logic             stat_ovr,
  output logic             stat_und
);
  localparam int DEPTH = BUF_BITS / SYM_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = SYM_W + 2;

  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [EW-1:0] wentry, rentry;

  rxeb_wr_side #(.SYM_W(SYM_W), .AW(AW)) u_wr (
    .clk(wclk), .rst(wrst), .dv(wr_dv), .data(wr_data), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wentry(wentry), .wgray(wgray)
  );

  rxeb_mem #(.DW(EW), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wentry),
    .raddr(raddr), .rdata(rentry)
  );

  rxeb_sync #(.W(AW+1), .STAGES(SYNC_STG)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  rxeb_sync #(.W(AW+1), .STAGES(SYNC_STG)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
  );

  rxeb_rd_side #(.SYM_W(SYM_W), .AW(AW)) u_rd (
    .clk(rclk), .rst(rrst), .thr_sel(thr_sel), .stat_rd(stat_rd),
    .wgray_s(wgray_s), .rentry(rentry), .raddr(raddr), .rgray(rgray),
    .rd_dv(rd_dv), .rd_data(rd_data), .rd_err(rd_err),
    .stat_ovr(stat_ovr), .stat_und(stat_und)
  );
endmodule

// File: rtl/rxeb_chk.sv
`timescale 1ns/1ps
module rxeb_chk #(
  parameter int AW = 4
) (
  input logic        wclk,
  input logic        wrst,
  input logic        rclk,
  input logic        rrst,
  input logic        rd_dv,
  input logic        rd_err,
  input logic        stat_ovr,
  input logic        stat_und,
  input logic        stat_rd,
  input logic [AW:0] wgray,
  input logic [AW:0] rgray
);
  // R6
  err_in_frame_chk: assert property (@(posedge rclk) disable iff (rrst)
    rd_err |-> rd_dv);

  // R6
  err_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
    (rd_dv && rd_err) |=> (rd_err || !rd_dv));

  // R7
  ovr_sticky_chk: assert property (@(posedge rclk) disable iff (rrst)
    (stat_ovr && !stat_rd) |=> stat_ovr);

  // R7
  und_sticky_chk: assert property (@(posedge rclk) disable iff (rrst)
    (stat_und && !stat_rd) |=> stat_und);

  // R5
  und_flag_chk: assert property (@(posedge rclk) disable iff (rrst)
    $rose(stat_und) |-> (rd_dv && rd_err));

  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (rrst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind rx_elastic_buf rxeb_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
  .rd_dv(rd_dv), .rd_err(rd_err), .stat_ovr(stat_ovr), .stat_und(stat_und),
  .stat_rd(stat_rd), .wgray(wgray), .rgray(rgray)
);

// File: tb/rx_elastic_buf_test.sv
`timescale 1ns/1ps
module rx_elastic_buf_test;
  localparam int SYM_W = 2;

  logic rclk = 1'b0, wclk = 1'b0;
  real  whalf = 3.98;
  logic wrst = 1'b1, rrst = 1'b1, wr_dv = 1'b0, stat_rd = 1'b0;
  logic [SYM_W-1:0] wr_data = '0;
  logic [1:0] thr_sel = 2'd0;
  logic rd_dv, rd_err, stat_ovr, stat_und;
  logic [SYM_W-1:0] rd_data;

  always #4 rclk = ~rclk;
  initial begin
    #1.3;
    forever #(whalf) wclk = ~wclk;
  end

  rx_elastic_buf uut (
    .wclk(wclk), .wrst(wrst), .wr_dv(wr_dv), .wr_data(wr_data),
    .rclk(rclk), .rrst(rrst), .thr_sel(thr_sel), .stat_rd(stat_rd),
    .rd_dv(rd_dv), .rd_data(rd_data), .rd_err(rd_err),
    .stat_ovr(stat_ovr), .stat_und(stat_und)
  );

  int checks = 0, fails = 0;
  logic [SYM_W-1:0] ib [256];
  logic [SYM_W-1:0] od [1024];
  logic             oe [1024];
  int  wcnt = 0, out_n = 0, first_w = 0;
  bit  done = 1'b0, prev_dv = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int thr_ent(input logic [1:0] sel);
    return ((sel == 2'd0) ? 16 : 4 * int'(sel)) / SYM_W;
  endfunction

  always @(posedge wclk) if (wr_dv) wcnt++;

  always @(negedge rclk) begin
    if (rd_dv) begin
      if (out_n == 0) first_w = wcnt;
      if (out_n < 1024) begin
        od[out_n] = rd_data;
        oe[out_n] = rd_err;
      end
      out_n++;
    end
    if (prev_dv && !rd_dv) done = 1'b1;
    prev_dv = rd_dv;
  end

  task automatic send_frame(input int len, input bit konst);
    out_n = 0; done = 1'b0; wcnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge wclk);
      wr_dv   = 1'b1;
      wr_data = konst ? 2'b01 : SYM_W'($urandom);
      ib[i]   = wr_data;
    end
    @(negedge wclk);
    wr_dv = 1'b0;
    for (int k = 0; k < 3000 && !done; k++) @(posedge rclk);
    chk(done, "R2", "frame end seen", int'(done), 1);
    repeat (6) @(negedge rclk);
  endtask

  task automatic check_clean(input int len);
    int mism = 0, errs = 0;
    for (int i = 0; i < out_n && i < len; i++) begin
      if (od[i] !== ib[i]) mism++;
      if (oe[i]) errs++;
    end
    chk(out_n == len, "R2", "symbol count", out_n, len);
    chk(mism == 0, "R2", "symbol mismatches", mism, 0);
    chk(errs == 0, "R2", "rd_err during clean frame", errs, 0);
    chk(first_w >= thr_ent(thr_sel) && first_w <= thr_ent(thr_sel) + 5,
        "R3", "symbols written before first output", first_w, thr_ent(thr_sel));
  endtask

  // Error frame analysis: constant 01 input, prefix untouched, then errors only
  task automatic check_err_frame(input string req);
    int fe = -1, bad_pre = 0, bad_post = 0, inv = 0, gaps = 0;
    for (int i = 0; i < out_n && i < 1024; i++) begin
      if (fe < 0 && oe[i]) fe = i;
      if (fe < 0) begin
        if (od[i] !== 2'b01) bad_pre++;
      end else begin
        if (!oe[i]) gaps++;
        if (od[i] === 2'b10) inv++;
        else if (od[i] !== 2'b11) bad_post++;
      end
    end
    chk(fe >= 0, req, "rd_err seen in frame", fe, 0);
    chk(bad_pre == 0, "R6", "corrupt symbols before error", bad_pre, 0);
    chk(gaps == 0, "R6", "rd_err dropped inside frame", gaps, 0);
    chk(bad_post == 0, "R6", "non-inverted symbols after error", bad_post, 0);
    chk(inv > 0, "R6", "inverted data symbols after error", inv, 1);
  endtask

  task automatic clear_status();
    @(negedge rclk) stat_rd = 1'b1;
    @(negedge rclk) stat_rd = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge rclk);
    wrst = 1'b0; rrst = 1'b0;
    repeat (3) @(negedge rclk);
    // R1: reset state
    chk(rd_dv == 1'b0, "R1", "rd_dv after reset", int'(rd_dv), 0);
    chk(rd_err == 1'b0, "R1", "rd_err after reset", int'(rd_err), 0);
    chk(stat_ovr == 1'b0, "R1", "stat_ovr after reset", int'(stat_ovr), 0);
    chk(stat_und == 1'b0, "R1", "stat_und after reset", int'(stat_und), 0);

    // R3: every threshold select, directed
    for (int s = 0; s < 4; s++) begin
      thr_sel = 2'(s);
      send_frame(24 + 4 * s, 1'b0);
      check_clean(24 + 4 * s);
    end

    // R2: random clean frames, random thresholds
    for (int f = 0; f < 12; f++) begin
      int len;
      thr_sel = 2'($urandom_range(3, 1));
      len = 16 + int'($urandom_range(48, 0));
      send_frame(len, 1'b0);
      check_clean(len);
    end
    chk(stat_ovr == 1'b0 && stat_und == 1'b0, "R2", "flags after clean frames",
        int'({stat_ovr, stat_und}), 0);

    // R4: writer 25 % fast, long frame overruns the 32-bit store
    thr_sel = 2'd0;
    whalf = 3.0;
    send_frame(120, 1'b1);
    check_err_frame("R4");
    chk(stat_ovr == 1'b1, "R4", "stat_ovr after overrun", int'(stat_ovr), 1);
    chk(stat_und == 1'b0, "R4", "stat_und after overrun", int'(stat_und), 0);

    // R7: flag survives a clean frame, then clears on stat_rd
    whalf = 3.98;
    thr_sel = 2'd2;
    send_frame(30, 1'b0);
    check_clean(30);
    chk(stat_ovr == 1'b1, "R7", "stat_ovr held", int'(stat_ovr), 1);
    clear_status();
    chk(stat_ovr == 1'b0, "R7", "stat_ovr after stat_rd", int'(stat_ovr), 0);

    // R5: writer 50 % slow, reader runs dry mid-frame
    thr_sel = 2'd1;
    whalf = 6.0;
    send_frame(40, 1'b1);
    check_err_frame("R5");
    chk(stat_und == 1'b1, "R5", "stat_und after underrun", int'(stat_und), 1);
    chk(stat_ovr == 1'b0, "R5", "stat_ovr after underrun", int'(stat_ovr), 0);
    begin
      int fills = 0;
      for (int i = 0; i < out_n && i < 1024; i++)
        if (oe[i] && od[i] === 2'b11) fills++;
      chk(fills > 0, "R5", "all-ones fill symbols", fills, 1);
    end
    clear_status();
    chk(stat_und == 1'b0, "R7", "stat_und after stat_rd", int'(stat_und), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule